// File: doc/BRIEF.md
# Keypad Group-Select Reader

This block lets a processor read an eight-button keypad through one byte-wide register. The buttons fall into two groups of four. The processor writes a two-bit group selector into the register. When it reads the register back, the low four bits show the buttons of the chosen group, with a pressed button reading as 0.

The raw pressed vector is active-high. Its bits 3:0 form the "low group" and its bits 7:4 form the "high group". Before use, the vector passes through a two-stage synchronizer. The two selector bits also choose two special cases:
- Selecting both groups merges them, so a press in either group shows up.
- Selecting neither group returns an identification nibble. The nibble depends on a multiplayer flag.

Writes are a single-cycle strobe. The read value is driven continuously. The register-access pins are plain control pins, and there is no stream handshake at this boundary.

Top module: `joy_select_reader`

## Requirements
- R1: After reset the stored selector is 2'b00, so the first read shows bits 5:4 as 0 and bits 7:6 as 1.
- R2: A write stores only bits 5:4 of the written byte into the selector, and the selector holds between writes. The other written bits never appear in the read value: bits 7:6 still read as 1 and bits 3:0 still follow the buttons.
- R3: With selector 2'b10, read bits 3:0 equal the inverse of synchronized pressed bits 7:4.
- R4: With selector 2'b01, read bits 3:0 equal the inverse of synchronized pressed bits 3:0.
- R5: With selector 2'b00, read bits 3:0 equal the inverse of (pressed bits 7:4 OR pressed bits 3:0).
- R6: With selector 2'b11, read bits 3:0 are 4'h0 while the multiplayer flag is 1, and 4'hF while it is 0.
- R7: The read byte is always {2'b11, selector[1:0], reported nibble inverted}.
- R8: A change on the pressed vector reaches the read value after exactly two rising clock edges. The multiplayer flag acts without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| btn_pressed_i | input | 8 | Pressed buttons, active-high; bits 3:0 low group, bits 7:4 high group |
| multi_mode_i | input | 1 | Multiplayer flag, used when neither group is selected |
| reg_wr_i | input | 1 | Write strobe for the select register |
| reg_wdata_i | input | 8 | Write data; only bits 5:4 are kept |
| reg_rdata_o | output | 8 | Current read value of the register |

## Verification
The main check drives one pattern per button group with the other group held at all zeros, so a wrongly chosen or swapped nibble shows up. It then presses buttons in both groups at once with different patterns, which separates OR from AND or from a plain pass-through in the merged mode. The deselected mode is tried with the multiplayer flag set and cleared while buttons are held, which shows that the buttons have no effect in that mode. Single-step button changes, with a read after each clock edge, expose a synchronizer that is one stage too short or too long.

// File: rtl/joy_pkg.sv
package joy_pkg;
  localparam int GROUP_W   = 4;
  localparam int BTN_W     = 2 * GROUP_W;
  localparam int REG_W     = 8;
  localparam int SEL_LSB   = 4;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    GRP_BOTH = 2'b00,
    GRP_LOW  = 2'b01,
    GRP_HIGH = 2'b10,
    GRP_NONE = 2'b11
  } grp_sel_e;

  localparam logic [GROUP_W-1:0] MULTI_ID = '1;
endpackage

// File: rtl/joy_sync.sv
module joy_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];
  logic         warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;
  end

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_i;
        end
        a_r8_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
          warm_q |-> stg[0] == $past(d_i));
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
        a_r8_chain_stage: assert property (@(posedge clk) disable iff (!rst_n)
          warm_q |-> stg[i] == $past(stg[i-1]));
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/joy_sel_reg.sv
module joy_sel_reg
  import joy_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output grp_sel_e         sel_o
);
  grp_sel_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= GRP_BOTH;
    else if (wr_i) sel_q <= grp_sel_e'(wdata_i[SEL_LSB +: SEL_W]);
  end

  assign sel_o = sel_q;

  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(sel_q));
  a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> sel_q == $past(wdata_i[SEL_LSB +: SEL_W]));
endmodule

// File: rtl/joy_group_mux.sv
module joy_group_mux
  import joy_pkg::*;
(
  input  grp_sel_e           sel_i,
  input  logic [BTN_W-1:0]   btn_i,
  input  logic               multi_i,
  output logic [GROUP_W-1:0] nib_o
);
  logic [GROUP_W-1:0] grp_lo, grp_hi;

  assign grp_lo = btn_i[0 +: GROUP_W];
  assign grp_hi = btn_i[GROUP_W +: GROUP_W];

  always_comb begin
    unique case (sel_i)
      GRP_HIGH: nib_o = grp_hi;
      GRP_LOW:  nib_o = grp_lo;
      GRP_BOTH: nib_o = grp_hi | grp_lo;
      default:  nib_o = multi_i ? MULTI_ID : '0;
    endcase
  end
endmodule

// File: rtl/joy_select_reader.sv
module joy_select_reader
  import joy_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] btn_pressed_i,
  input  logic       multi_mode_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  localparam int TOP_W = REG_W - SEL_LSB - SEL_W;

  logic [BTN_W-1:0]   btn_sync;
  grp_sel_e           sel;
  logic [GROUP_W-1:0] nib;

  joy_sync #(.W(BTN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(btn_pressed_i), .q_o(btn_sync)
  );

  joy_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .sel_o(sel)
  );

  joy_group_mux u_mux (
    .sel_i(sel), .btn_i(btn_sync), .multi_i(multi_mode_i), .nib_o(nib)
  );

  assign reg_rdata_o = {{TOP_W{1'b1}}, sel, ~nib};

  a_r7_top_ones: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[REG_W-1 -: TOP_W] == '1);
  a_r6_multi_id: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == GRP_NONE) |-> reg_rdata_o[GROUP_W-1:0] == (multi_mode_i ? 4'h0 : 4'hF));
  a_r3_high_group: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == GRP_HIGH) |-> reg_rdata_o[GROUP_W-1:0] == ~btn_sync[BTN_W-1 -: GROUP_W]);
  a_r4_low_group: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == GRP_LOW) |-> reg_rdata_o[GROUP_W-1:0] == ~btn_sync[GROUP_W-1:0]);
  a_r5_merged: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == GRP_BOTH) |-> reg_rdata_o[GROUP_W-1:0] ==
      ~(btn_sync[GROUP_W-1:0] | btn_sync[BTN_W-1 -: GROUP_W]));
endmodule

// File: tb/joy_select_reader_test.sv
`timescale 1ns/100ps
module joy_select_reader_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] btn = 8'h00;
  logic       multi = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] hist [$];
  int         sel_m = 0;

  always #2.5 clk = ~clk;

  joy_select_reader uut (
    .clk(clk), .rst_n(rst_n), .btn_pressed_i(btn), .multi_mode_i(multi),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      sel_m = 0;
      hist = '{8'h00, 8'h00};
    end else begin
      if (wr) sel_m = (wdata >> 4) & 3;
      hist.push_front(btn);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] model_read();
    logic [7:0] s;
    logic [3:0] n;
    s = hist[1];
    case (sel_m)
      2:       n = s[7:4];
      1:       n = s[3:0];
      0:       n = s[7:4] | s[3:0];
      default: n = multi ? 4'hF : 4'h0;
    endcase
    return {2'b11, sel_m[1:0], ~n};
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (sel_m)
        2: check(rdata, model_read(), "R3 high group");
        1: check(rdata, model_read(), "R4 low group");
        0: check(rdata, model_read(), "R5 merged");
        default: check(rdata, model_read(), "R6 id nibble");
      endcase
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    tick(1);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    #1;
    // R1 reset value with no buttons
    check(rdata, 8'hCF, "R1 reset");
    tick(2);
    // R4 low group, R3 high group with the opposite group idle
    wr_reg(8'h10);
    btn = 8'h05; tick(3);
    check(rdata, 8'hDA, "R4 low 0x5");
    btn = 8'h50; tick(3);
    check(rdata, 8'hDF, "R4 high ignored");
    wr_reg(8'h20); tick(1);
    check(rdata, 8'hEA, "R3 high 0x5");
    btn = 8'h09; tick(3);
    check(rdata, 8'hEF, "R3 low ignored");
    // R5 merge of distinct patterns
    wr_reg(8'h00);
    btn = 8'h3C; tick(3);
    check(rdata, 8'hC0, "R5 or 3|C");
    btn = 8'h21; tick(3);
    check(rdata, 8'hCC, "R5 or 2|1");
    // R6 id nibble with buttons held
    wr_reg(8'h30);
    btn = 8'hFF; multi = 1'b0; tick(3);
    check(rdata, 8'hFF, "R6 multi off");
    multi = 1'b1; #1;
    check(rdata, 8'hF0, "R6 multi on, R8 no delay");
    multi = 1'b0;
    // R2/R7 only bits 5:4 kept
    wr_reg(8'hCF);
    btn = 8'h00; tick(3);
    check(rdata, 8'hCF, "R2 other bits dropped");
    wr_reg(8'h9A);
    btn = 8'h02; tick(3);
    check(rdata, 8'hDD, "R2 R7 sel 01 from 0x9A");
    tick(5);
    check(rdata, 8'hDD, "R2 hold");
    // R8 two-edge latency
    btn = 8'h08;
    tick(1);
    check(rdata, 8'hDD, "R8 after one edge");
    tick(1);
    check(rdata, 8'hD7, "R8 after two edges");
    // varied stream across all modes
    for (int k = 0; k < 200; k++) begin
      btn = 8'((k * 37 + 11) ^ (k >> 2));
      multi = k[3];
      if (k % 7 == 0) wr_reg(8'((k * 13) ^ 8'hA5));
      else tick(1);
    end
    tick(3);
    finish_run();
  end
endmodule